// File: doc/BRIEF.md
# Tiled Matrix Multiply Sequencer

This block computes C = A×B for an M×K matrix A and a K×N matrix B held in on-chip memories, using an external multiply-accumulate engine that works on 4×4 tiles. On a start pulse it captures the three dimensions and walks the output matrix one 4×4 tile at a time. It moves across the tile columns of a tile row before it moves to the next tile row. For each output tile it zeroes a local accumulator tile. It then steps through the inner dimension in strides of 4. At each stride it gathers one A tile and one B tile word by word, hands both to the engine together with the running accumulator, and takes back the updated accumulator. When the last inner stride is done it writes the finished tile to the C memory.

All matrices are stored row-major with one element per memory word. Element (r, c) of A lives at r·K + c, of B at r·N + c, and of C at r·N + c. The A and B memories have one read port each, with a read latency of one cycle. Dimensions that are zero or not a multiple of 4 are refused: the block raises an error flag and finishes at once without touching any memory or the engine.

Top module: `mm_tile_seq`

## Requirements
- R1: While reset is held, busy, done, err, aRdEn, bRdEn, macReq and cWrEn are all low.
- R2: A start seen while idle with any of M, N, K equal to zero or not divisible by 4 produces done and err together on the following cycle. It produces no C write and no engine request. err stays high until the next accepted start, and that start clears it when its dimensions are legal.
- R3: For legal dimensions, every C word at r·N + c (r < M, c < N) ends up holding the sum over t of A[r·K+t]·B[t·N+c], taken modulo 2^AW.
- R4: A run writes exactly M·N C words, each address once. Writes occur only while busy, and never in a cycle with an engine request or an A read.
- R5: A run issues exactly (M/4)·(N/4)·(K/4) engine requests.
- R6: The accumulator tile is zeroed at the start of each output tile, so no partial sum carries from one tile or one run to the next.
- R7: Output tiles are written in order: tile columns within a tile row, then tile rows. Within a tile the order is row by row, 4 words per row. A tile's first write follows exactly K/4 engine completions since the previous tile's last write.
- R8: On the engine buses macA, macB, macAcc and macResult, tile element (row r, column c) sits in slot s = 4·r + c, at bits s·width upward. The A tile of inner stride k covers rows i..i+3 and columns k..k+3 of A. The B tile covers rows k..k+3 and columns j..j+3 of B.
- R9: macReq is high for exactly one cycle per operation and is not raised again until macDone has returned the result.
- R10: done is a one-cycle pulse, after which busy is low and the block is idle.
- R11: A start pulse while busy is ignored; the run in progress completes with its original dimensions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiply when idle |
| dimM | input | DIMW | Rows of A and C |
| dimN | input | DIMW | Columns of B and C |
| dimK | input | DIMW | Columns of A, rows of B |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Last start had illegal dimensions |
| aRdEn | output | 1 | A memory read enable |
| aAddr | output | ADDRW | A memory word address |
| aRdData | input | DW | A memory read data, one cycle after the address |
| bRdEn | output | 1 | B memory read enable |
| bAddr | output | ADDRW | B memory word address |
| bRdData | input | DW | B memory read data, one cycle after the address |
| macReq | output | 1 | Engine operation request |
| macA | output | 16·DW | A tile operand |
| macB | output | 16·DW | B tile operand |
| macAcc | output | 16·AW | Running accumulator operand |
| macDone | input | 1 | Engine result valid |
| macResult | input | 16·AW | Updated accumulator from the engine |
| cWrEn | output | 1 | C memory write enable |
| cAddr | output | ADDRW | C memory word address |
| cWrData | output | AW | C memory write data |

## Verification
The hardest situation to reach is a carry-over fault. Stale accumulator or tile-register contents only show up when one run follows another, or one output tile follows another, with different data. The stimulus therefore runs several multi-tile shapes back to back, and it repeats the largest shape with fresh matrix contents. A stray start is also injected in the middle of a run, so that a wrongly accepted restart would corrupt the results. The bench's engine model answers after varying latencies, so that the wait between request and completion is exercised at zero and at several cycles.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int TILE  = 4;
  localparam int TELEM = TILE * TILE;
  localparam int IDXW  = $clog2(TELEM);

  typedef enum logic [2:0] {
    S_IDLE, S_CLEAR, S_LOAD, S_MAC, S_WAIT, S_STORE, S_DONE
  } mmState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic            clrAcc;
    logic            capEn;
    logic [IDXW-1:0] capIdx;
    logic            accLoad;
  } mmCtrl_t;
endpackage

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int DIMW  = 8,
  parameter int ADDRW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIMW-1:0]  dimM,
  input  logic [DIMW-1:0]  dimN,
  input  logic [DIMW-1:0]  dimK,
  input  logic             macDone,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             aRdEn,
  output logic [ADDRW-1:0] aAddr,
  output logic             bRdEn,
  output logic [ADDRW-1:0] bAddr,
  output logic             macReq,
  output logic             cWrEn,
  output logic [ADDRW-1:0] cAddr,
  output logic [IDXW-1:0]  cIdx,
  output mmCtrl_t          ctrl
);
  localparam logic [DIMW:0]   STEP  = (DIMW+1)'(TILE);
  localparam logic [DIMW-1:0] TSTEP = DIMW'(TILE);

  mmState_t state;
  logic [DIMW-1:0] mR, nR, kR, ti, tj, tk;
  logic [IDXW:0]   cnt;
  logic            rdValid, errR;
  logic [IDXW-1:0] rdIdx;

  logic [1:0] eRow, eCol;
  logic       badDims, lastK, lastCol, lastRow;

  assign eRow = cnt[3:2];
  assign eCol = cnt[1:0];

  assign badDims = (dimM == '0) || (dimN == '0) || (dimK == '0) ||
                   ((dimM % TSTEP) != '0) || ((dimN % TSTEP) != '0) ||
                   ((dimK % TSTEP) != '0);
  assign lastK   = ({1'b0, tk} + STEP) == {1'b0, kR};
  assign lastCol = ({1'b0, tj} + STEP) == {1'b0, nR};
  assign lastRow = ({1'b0, ti} + STEP) == {1'b0, mR};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      {mR, nR, kR} <= '0;
      {ti, tj, tk} <= '0;
      cnt     <= '0;
      rdValid <= 1'b0;
      rdIdx   <= '0;
      errR    <= 1'b0;
    end else begin
      rdValid <= (state == S_LOAD) && !cnt[IDXW];
      rdIdx   <= cnt[IDXW-1:0];
      unique case (state)
        S_IDLE: if (start) begin
          errR  <= badDims;
          mR    <= dimM;
          nR    <= dimN;
          kR    <= dimK;
          ti    <= '0;
          tj    <= '0;
          state <= badDims ? S_DONE : S_CLEAR;
        end
        S_CLEAR: begin
          tk    <= '0;
          cnt   <= '0;
          state <= S_LOAD;
        end
        S_LOAD: begin
          if (cnt[IDXW]) state <= S_MAC;
          else           cnt   <= cnt + 1'b1;
        end
        S_MAC: state <= S_WAIT;
        S_WAIT: if (macDone) begin
          cnt <= '0;
          if (lastK) state <= S_STORE;
          else begin
            tk    <= tk + TSTEP;
            state <= S_LOAD;
          end
        end
        S_STORE: begin
          if (cnt[IDXW-1:0] == IDXW'(TELEM-1)) begin
            if (lastCol) begin
              tj <= '0;
              if (lastRow) state <= S_DONE;
              else begin
                ti    <= ti + TSTEP;
                state <= S_CLEAR;
              end
            end else begin
              tj    <= tj + TSTEP;
              state <= S_CLEAR;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    aAddr = (ADDRW'(ti) + ADDRW'(eRow)) * ADDRW'(kR) + ADDRW'(tk) + ADDRW'(eCol);
    bAddr = (ADDRW'(tk) + ADDRW'(eRow)) * ADDRW'(nR) + ADDRW'(tj) + ADDRW'(eCol);
    cAddr = (ADDRW'(ti) + ADDRW'(eRow)) * ADDRW'(nR) + ADDRW'(tj) + ADDRW'(eCol);
  end

  assign busy   = (state != S_IDLE);
  assign done   = (state == S_DONE);
  assign err    = errR;
  assign aRdEn  = (state == S_LOAD) && !cnt[IDXW];
  assign bRdEn  = aRdEn;
  assign macReq = (state == S_MAC);
  assign cWrEn  = (state == S_STORE);
  assign cIdx   = cnt[IDXW-1:0];

  assign ctrl.clrAcc  = (state == S_CLEAR);
  assign ctrl.capEn   = rdValid;
  assign ctrl.capIdx  = rdIdx;
  assign ctrl.accLoad = (state == S_WAIT) && macDone;
endmodule

// File: rtl/mm_datapath.sv
module mm_datapath
  import mm_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  mmCtrl_t             ctrl,
  input  logic [DW-1:0]       aRdData,
  input  logic [DW-1:0]       bRdData,
  input  logic [TELEM*AW-1:0] macResult,
  input  logic [IDXW-1:0]     cIdx,
  output logic [TELEM*DW-1:0] macA,
  output logic [TELEM*DW-1:0] macB,
  output logic [TELEM*AW-1:0] macAcc,
  output logic [AW-1:0]       cWrData
);
  for (genvar e = 0; e < TELEM; e++) begin : gElem
    logic hit;
    assign hit = ctrl.capEn && (ctrl.capIdx == IDXW'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        macA[e*DW +: DW]   <= '0;
        macB[e*DW +: DW]   <= '0;
        macAcc[e*AW +: AW] <= '0;
      end else begin
        if (hit) begin
          macA[e*DW +: DW] <= aRdData;
          macB[e*DW +: DW] <= bRdData;
        end
        if (ctrl.clrAcc)       macAcc[e*AW +: AW] <= '0;
        else if (ctrl.accLoad) macAcc[e*AW +: AW] <= macResult[e*AW +: AW];
      end
    end
  end

  assign cWrData = macAcc[cIdx*AW +: AW];
endmodule

// File: rtl/mm_tile_seq.sv
module mm_tile_seq
  import mm_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 32,
  parameter int DIMW  = 8,
  parameter int ADDRW = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [DIMW-1:0]     dimM,
  input  logic [DIMW-1:0]     dimN,
  input  logic [DIMW-1:0]     dimK,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic                aRdEn,
  output logic [ADDRW-1:0]    aAddr,
  input  logic [DW-1:0]       aRdData,
  output logic                bRdEn,
  output logic [ADDRW-1:0]    bAddr,
  input  logic [DW-1:0]       bRdData,
  output logic                macReq,
  output logic [TELEM*DW-1:0] macA,
  output logic [TELEM*DW-1:0] macB,
  output logic [TELEM*AW-1:0] macAcc,
  input  logic                macDone,
  input  logic [TELEM*AW-1:0] macResult,
  output logic                cWrEn,
  output logic [ADDRW-1:0]    cAddr,
  output logic [AW-1:0]       cWrData
);
  mmCtrl_t         ctrl;
  logic [IDXW-1:0] cIdx;

  mm_ctrl #(.DIMW(DIMW), .ADDRW(ADDRW)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .dimM(dimM), .dimN(dimN), .dimK(dimK), .macDone(macDone),
    .busy(busy), .done(done), .err(err),
    .aRdEn(aRdEn), .aAddr(aAddr), .bRdEn(bRdEn), .bAddr(bAddr),
    .macReq(macReq), .cWrEn(cWrEn), .cAddr(cAddr), .cIdx(cIdx),
    .ctrl(ctrl)
  );

  mm_datapath #(.DW(DW), .AW(AW)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .aRdData(aRdData), .bRdData(bRdData), .macResult(macResult),
    .cIdx(cIdx), .macA(macA), .macB(macB), .macAcc(macAcc),
    .cWrData(cWrData)
  );
endmodule

// File: rtl/mm_tile_seq_chk.sv
module mm_tile_seq_chk #(
  parameter int DIMW = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic [DIMW-1:0] dimM,
  input logic [DIMW-1:0] dimN,
  input logic [DIMW-1:0] dimK,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic            aRdEn,
  input logic            macReq,
  input logic            macDone,
  input logic            cWrEn
);
  logic illegal;
  assign illegal = (dimM == '0) || (dimN == '0) || (dimK == '0) ||
                   (dimM[1:0] != 2'b00) || (dimN[1:0] != 2'b00) ||
                   (dimK[1:0] != 2'b00);

  logic pending;
  always_ff @(posedge clk) begin
    if (!rstN)        pending <= 1'b0;
    else if (macReq)  pending <= 1'b1;
    else if (macDone) pending <= 1'b0;
  end

  // R2
  bad_dims_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && illegal) |=> (done && err));

  // R4
  store_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cWrEn |-> (busy && !macReq && !aRdEn));

  // R9
  mac_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    macReq |=> !macReq);

  // R9
  mac_no_reissue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !macDone) |-> !macReq);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
endmodule

bind mm_tile_seq mm_tile_seq_chk #(.DIMW(DIMW)) uChk (
  .clk(clk), .rstN(rstN), .start(start),
  .dimM(dimM), .dimN(dimN), .dimK(dimK),
  .busy(busy), .done(done), .err(err), .aRdEn(aRdEn),
  .macReq(macReq), .macDone(macDone), .cWrEn(cWrEn)
);

// File: tb/sim_mm_tile_seq.sv
`timescale 1ns/1ps
module sim_mm_tile_seq;
  import mm_pkg::*;
  localparam int DW = 16, AW = 32, DIMW = 8, ADDRW = 16;
  localparam int MEMD = 256;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [DIMW-1:0] dimM = '0, dimN = '0, dimK = '0;
  logic busy, done, err, aRdEn, bRdEn, macReq, cWrEn;
  logic [ADDRW-1:0] aAddr, bAddr, cAddr;
  logic [DW-1:0] aRdData = '0, bRdData = '0;
  logic [TELEM*DW-1:0] macA, macB;
  logic [TELEM*AW-1:0] macAcc, macResult = '0;
  logic macDone = 1'b0;
  logic [AW-1:0] cWrData;

  always #4 clk = ~clk;

  mm_tile_seq #(.DW(DW), .AW(AW), .DIMW(DIMW), .ADDRW(ADDRW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .dimM(dimM), .dimN(dimN), .dimK(dimK),
    .busy(busy), .done(done), .err(err),
    .aRdEn(aRdEn), .aAddr(aAddr), .aRdData(aRdData),
    .bRdEn(bRdEn), .bAddr(bAddr), .bRdData(bRdData),
    .macReq(macReq), .macA(macA), .macB(macB), .macAcc(macAcc),
    .macDone(macDone), .macResult(macResult),
    .cWrEn(cWrEn), .cAddr(cAddr), .cWrData(cWrData)
  );

  logic [DW-1:0] memA [MEMD];
  logic [DW-1:0] memB [MEMD];
  logic [AW-1:0] memC [MEMD];
  int hits [MEMD];
  int checks = 0, errors = 0;
  int curN = 4, curK = 4, macLat = 0;
  logic clearMon = 1'b0;
  int wrCnt, macCnt, orderErr, tileErr, reissueErr, tileMacs;
  logic macPend;
  int latCnt;
  logic [TELEM*AW-1:0] pendRes;

  // R8: slot 4*r+c carries element (r,c)
  function automatic logic [TELEM*AW-1:0] macFn(input logic [TELEM*DW-1:0] a,
      input logic [TELEM*DW-1:0] b, input logic [TELEM*AW-1:0] acc);
    logic [TELEM*AW-1:0] res;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        logic [AW-1:0] s;
        s = acc[(r*4+c)*AW +: AW];
        for (int t = 0; t < 4; t++)
          s = s + AW'(a[(r*4+t)*DW +: DW]) * AW'(b[(t*4+c)*DW +: DW]);
        res[(r*4+c)*AW +: AW] = s;
      end
    return res;
  endfunction

  always @(posedge clk) aRdData <= memA[aAddr[7:0]];
  always @(posedge clk) bRdData <= memB[bAddr[7:0]];

  // Engine model and monitors
  always @(posedge clk) begin
    if (clearMon || !rstN) begin
      wrCnt = 0; macCnt = 0; orderErr = 0; tileErr = 0; reissueErr = 0; tileMacs = 0;
      macPend <= 1'b0; macDone <= 1'b0; latCnt = 0;
      for (int i = 0; i < MEMD; i++) begin hits[i] = 0; memC[i] = 32'hDEADBEEF; end
    end else begin
      if (macPend) begin
        if (macReq) reissueErr++;
        if (latCnt == 0) begin
          macDone <= 1'b1; macResult <= pendRes; macPend <= 1'b0;
        end else latCnt--;
      end else begin
        macDone <= 1'b0;
        if (macReq) begin
          pendRes = macFn(macA, macB, macAcc);
          macPend <= 1'b1; latCnt = macLat; macCnt++; tileMacs++;
        end
      end
      if (cWrEn) begin
        int t, e, ti, tj, expA;
        t = wrCnt / 16; e = wrCnt % 16;
        ti = t / (curN / 4); tj = t % (curN / 4);
        expA = (ti*4 + e/4) * curN + tj*4 + e%4;
        if (int'(cAddr) != expA) orderErr++;
        if (e == 0 && tileMacs != curK/4) tileErr++;
        if (e == 15) tileMacs = 0;
        memC[cAddr[7:0]] = cWrData;
        hits[cAddr[7:0]]++;
        wrCnt++;
      end
    end
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill(input int m, input int n, input int k, input int seed);
    for (int i = 0; i < m*k; i++) memA[i] = DW'((i*7 + seed*13) % 251);
    for (int i = 0; i < k*n; i++) memB[i] = DW'((i*11 + seed*5 + 3) % 241);
    @(negedge clk) clearMon = 1'b1;
    @(negedge clk) clearMon = 1'b0;
  endtask

  task automatic pulseStart(input int m, input int n, input int k);
    dimM = DIMW'(m); dimN = DIMW'(n); dimK = DIMW'(k); start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitDone();
    int g = 0;
    while (!done && g < 50000) begin @(negedge clk); g++; end
    chk("R10 done seen", done, done, 1);
    @(negedge clk);
    chk("R10 done pulse then idle", !done && !busy, {done, busy}, 0);
  endtask

  task automatic runCase(input int m, input int n, input int k, input int seed,
                         input int lat, input bit midStart);
    int bad = 0, multi = 0;
    curN = n; curK = k; macLat = lat;
    fill(m, n, k, seed);
    pulseStart(m, n, k);
    if (midStart) begin
      repeat (20) @(negedge clk);
      pulseStart(4, 4, 4);
    end
    waitDone();
    for (int r = 0; r < m; r++)
      for (int c = 0; c < n; c++) begin
        logic [AW-1:0] s = '0;
        for (int t = 0; t < k; t++) s = s + AW'(memA[r*k+t]) * AW'(memB[t*n+c]);
        if (memC[r*n+c] != s) bad++;
        if (hits[r*n+c] != 1) multi++;
      end
    chk(midStart ? "R11 run unaffected" : "R3 R8 C matrix", bad == 0, bad, 0);
    chk("R6 no stale partial sum", bad == 0, bad, 0);
    chk("R4 write count", wrCnt == m*n, wrCnt, m*n);
    chk("R4 single write per word", multi == 0, multi, 0);
    chk("R5 engine ops", macCnt == (m/4)*(n/4)*(k/4), macCnt, (m/4)*(n/4)*(k/4));
    chk("R7 write order", orderErr == 0, orderErr, 0);
    chk("R7 writes after K/4 ops", tileErr == 0, tileErr, 0);
    chk("R9 no reissue", reissueErr == 0, reissueErr, 0);
    chk("R2 err low for legal run", err == 1'b0, err, 0);
  endtask

  task automatic badCase(input int m, input int n, input int k);
    curN = 4; curK = 4;
    fill(4, 4, 4, 1);
    pulseStart(m, n, k);
    chk("R2 done with err", done && err, {done, err}, 3);
    @(negedge clk);
    chk("R2 err held", err == 1'b1, err, 1);
    chk("R2 no writes or ops", wrCnt == 0 && macCnt == 0, wrCnt + macCnt, 0);
    chk("R10 idle after refusal", !busy && !done, {busy, done}, 0);
  endtask

  // {M, N, K, seed, latency}
  localparam logic [39:0] VEC [6] = '{
    {8'd4,  8'd4, 8'd4,  8'd1, 8'd0},
    {8'd8,  8'd4, 8'd12, 8'd2, 8'd1},
    {8'd4,  8'd8, 8'd8,  8'd3, 8'd3},
    {8'd12, 8'd8, 8'd4,  8'd4, 8'd0},
    {8'd8,  8'd8, 8'd16, 8'd5, 8'd2},
    {8'd8,  8'd8, 8'd16, 8'd9, 8'd0}
  };

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", !busy && !done && !err && !aRdEn && !bRdEn && !macReq && !cWrEn,
        {busy, done, err, aRdEn, bRdEn, macReq, cWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 6; v++)
      runCase(int'(VEC[v][39:32]), int'(VEC[v][31:24]), int'(VEC[v][23:16]),
              int'(VEC[v][15:8]), int'(VEC[v][7:0]), 1'b0);
    badCase(6, 4, 4);
    badCase(4, 0, 4);
    badCase(4, 4, 2);
    runCase(8, 8, 8, 6, 1, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule